// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Controller

This block sits between a byte-wide receive stream and a packet buffer. It follows each frame from its start strobe to its end strobe, decides whether the frame is kept, and generates the write strobes that move its bytes into the buffer. The decision looks at the destination address: an exact match against the station address, the all-ones broadcast address, multicast frames, or promiscuous mode. Collisions, oversize frames and the receiver enable can each stop a frame. The multicast hash lookup is done elsewhere and arrives as one match bit.

Bytes are written while the frame arrives. After the end strobe the block gives a one-cycle done pulse. With the pulse come the accept/drop verdict and the number of bytes stored. The buffer manager commits the frame only when the verdict is accept. When stripping is on, the trailing four check-sequence bytes are held back in a short delay line. They never reach the buffer and they are not counted. A sticky status bit records that a frame was cut for exceeding the length limit. It stays set until a clear strobe from the CPU or a reset.

Top module: `rx_accept_ctrl`

## Requirements
- R1: After reset all outputs are 0. The receiver is disabled, so a frame whose start byte arrives while `rx_en_i` is 0 produces no buffer write and no done pulse.
- R2: Without promiscuous mode, a frame whose first destination byte has bit 0 equal to 0 is accepted only when its six destination bytes equal the station address. Received byte k is compared with `station_addr_i[8k+7:8k]`, so byte 0 is the first byte received.
- R3: A frame whose six destination bytes are all 8'hFF is always accepted.
- R4: A frame whose first byte has bit 0 set, and which is not broadcast, is accepted when `all_mcast_i` is 1, or when `mcast_hit_i` is 1 at the edge that samples the last byte.
- R5: With `promisc_i` set, every frame is accepted, including frames shorter than six bytes. Without it, frames shorter than six bytes are dropped.
- R6: With `strip_crc_i` set at frame start, the last 4 bytes are not written and not counted. The count is the frame length minus 4, and never less than 0.
- R7: With stripping off, every byte of an accepted frame is written in order and the count equals the frame length.
- R8: Clearing `rx_en_i` during a frame lets that frame complete normally. Frames starting afterwards are ignored.
- R9: A frame longer than MAX_LEN (2048) bytes is dropped and sets `oversize_o`. A frame of exactly MAX_LEN bytes is accepted.
- R10: `oversize_o` stays set through later frames. Only reset or a one-cycle `oversize_clr_i` strobe clears it, and it reads 0 in the cycle after the strobe.
- R11: With `col_abort_i` set and `full_duplex_i` clear, `col_i` asserted during a frame drops it. With either setting otherwise, collisions have no effect.
- R12: `done_o` is a one-cycle pulse in the cycle after the edge that samples the last byte. `accept_o` and `byte_cnt_o` are valid in that cycle, and a dropped frame reports accept 0 and count 0.
- R13: Every buffer write follows, by one cycle, an edge at which a valid input byte was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte valid |
| sof_i | input | 1 | First byte of frame (with valid_i) |
| eof_i | input | 1 | Last byte of frame (with valid_i) |
| data_i | input | 8 | Received byte |
| col_i | input | 1 | Collision indication |
| rx_en_i | input | 1 | Receiver enable |
| promisc_i | input | 1 | Accept every frame |
| all_mcast_i | input | 1 | Accept every multicast frame |
| strip_crc_i | input | 1 | Drop trailing 4 bytes from buffer and count |
| col_abort_i | input | 1 | Abort frame on collision |
| full_duplex_i | input | 1 | Full duplex; disables collision abort |
| mcast_hit_i | input | 1 | Multicast table match for current frame |
| station_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| oversize_clr_i | input | 1 | CPU clear strobe for oversize status |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_data_o | output | 8 | Buffer write byte |
| done_o | output | 1 | Frame verdict pulse |
| accept_o | output | 1 | Frame accepted (valid with done_o) |
| byte_cnt_o | output | 12 | Stored byte count (valid with done_o) |
| oversize_o | output | 1 | Sticky oversize abort status |

## Verification
The verdict, count and done pulse are registered at the edge that samples the last byte. The bench drives that byte at a falling edge and reads all three at the next falling edge. At the falling edge after that it confirms the pulse has gone. Buffer writes lag their triggering byte by one cycle when stripping is off and by five byte times when it is on. A falling-edge monitor collects them, and the bench compares the collected bytes only after the done cycle has passed, so the last write is already in. The oversize clear is checked one falling edge after the strobe, which is the first cycle its register can show the change.

// File: rtl/rx_accept_pkg.sv
package rx_accept_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam logic [7:0]  BCAST_BYTE = 8'hFF;

  typedef struct packed {
    logic promisc;
    logic all_mcast;
    logic strip_crc;
    logic col_abort;
    logic full_duplex;
  } rx_cfg_t;
endpackage

// File: rtl/rx_len_track.sv
module rx_len_track #(
  parameter int unsigned MAX_LEN = 2048,
  parameter int unsigned CW      = $clog2(MAX_LEN + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          beat_i,
  output logic [CW-1:0] seen_o,   // bytes before current one
  output logic [CW-1:0] total_o,  // bytes including current one
  output logic          over_o
);
  localparam logic [CW-1:0] SAT = CW'(MAX_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    seen_o  = start_i ? '0 : cnt_q;
    total_o = (seen_o == SAT) ? seen_o : seen_o + 1'b1;
    over_o  = total_o > CW'(MAX_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (beat_i) cnt_q <= total_o;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_accept_pkg::*;
#(
  parameter int unsigned IW = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    beat_i,
  input  logic [IW-1:0]           idx_i,
  input  logic [7:0]              data_i,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  input  logic                    promisc_i,
  input  logic                    all_mcast_i,
  input  logic                    mcast_hit_i,
  output logic                    pass_o
);
  logic mc_q, uni_q, bc_q;
  logic mc_n, uni_n, bc_n, in_addr, full_addr;
  logic [7:0] stn_byte;

  always_comb begin
    stn_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx_i == IW'(k)) stn_byte = station_addr_i[8*k +: 8];
    in_addr   = idx_i < IW'(ADDR_BYTES);
    full_addr = idx_i >= IW'(ADDR_BYTES - 1);
    mc_n  = start_i ? data_i[0] : mc_q;
    uni_n = (start_i | uni_q) & (!in_addr | (data_i == stn_byte));
    bc_n  = (start_i | bc_q)  & (!in_addr | (data_i == BCAST_BYTE));
    pass_o = promisc_i |
             (full_addr & (bc_n | (mc_n ? (all_mcast_i | mcast_hit_i) : uni_n)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q <= 1'b0; uni_q <= 1'b0; bc_q <= 1'b0;
    end else if (beat_i) begin
      mc_q <= mc_n; uni_q <= uni_n; bc_q <= bc_n;
    end
  end
endmodule

// File: rtl/rx_crc_strip.sv
module rx_crc_strip #(
  parameter int unsigned CRC_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       beat_i,
  input  logic       strip_i,
  input  logic       kill_i,
  input  logic [7:0] data_i,
  output logic       wr_o,
  output logic [7:0] data_o
);
  logic       emit;
  logic [7:0] out_byte;

  if (CRC_LEN > 0) begin : g_dly
    localparam int unsigned FW = $clog2(CRC_LEN + 1);
    logic [7:0]    dly_q [CRC_LEN];
    logic [FW-1:0] fill_q, fill_b;

    always_comb begin
      fill_b   = start_i ? '0 : fill_q;
      emit     = strip_i ? (fill_b == FW'(CRC_LEN)) : 1'b1;
      out_byte = strip_i ? dly_q[CRC_LEN-1] : data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fill_q <= '0;
        for (int k = 0; k < CRC_LEN; k++) dly_q[k] <= '0;
      end else if (beat_i) begin
        fill_q   <= (fill_b == FW'(CRC_LEN)) ? fill_b : fill_b + 1'b1;
        dly_q[0] <= data_i;
        for (int k = 1; k < CRC_LEN; k++) dly_q[k] <= dly_q[k-1];
      end
    end
  end else begin : g_pass
    always_comb begin
      emit     = 1'b1;
      out_byte = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      data_o <= '0;
    end else begin
      wr_o <= beat_i & emit & !kill_i;
      if (beat_i) data_o <= out_byte;
    end
  end
endmodule

// File: rtl/rx_accept_ctrl.sv
module rx_accept_ctrl
  import rx_accept_pkg::*;
#(
  parameter int unsigned MAX_LEN = 2048,
  parameter int unsigned CRC_LEN = 4,
  localparam int unsigned CW     = $clog2(MAX_LEN + 2)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sof_i,
  input  logic                    eof_i,
  input  logic [7:0]              data_i,
  input  logic                    col_i,
  input  logic                    rx_en_i,
  input  logic                    promisc_i,
  input  logic                    all_mcast_i,
  input  logic                    strip_crc_i,
  input  logic                    col_abort_i,
  input  logic                    full_duplex_i,
  input  logic                    mcast_hit_i,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  input  logic                    oversize_clr_i,
  output logic                    buf_wr_o,
  output logic [7:0]              buf_data_o,
  output logic                    done_o,
  output logic                    accept_o,
  output logic [CW-1:0]           byte_cnt_o,
  output logic                    oversize_o
);
  rx_cfg_t cfg;
  assign cfg = '{promisc: promisc_i, all_mcast: all_mcast_i, strip_crc: strip_crc_i,
                 col_abort: col_abort_i, full_duplex: full_duplex_i};

  logic in_frame_q, drop_q, strip_q;
  logic start, beat, last, strip_eff, col_hit, drop_n, pass, over;
  logic [CW-1:0] seen, total, stored;

  always_comb begin
    start     = valid_i & sof_i & rx_en_i;
    beat      = start | (in_frame_q & valid_i);
    last      = beat & eof_i;
    strip_eff = start ? cfg.strip_crc : strip_q;
    col_hit   = col_i & cfg.col_abort & !cfg.full_duplex & (in_frame_q | start);
    drop_n    = (!start & drop_q) | col_hit | (beat & over);
    if (strip_eff)
      stored = (total >= CW'(CRC_LEN)) ? total - CW'(CRC_LEN) : '0;
    else
      stored = total;
  end

  rx_len_track #(.MAX_LEN(MAX_LEN), .CW(CW)) u_len (
    .clk_i, .rst_ni, .start_i(start), .beat_i(beat),
    .seen_o(seen), .total_o(total), .over_o(over)
  );

  rx_addr_filter #(.IW(CW)) u_filt (
    .clk_i, .rst_ni, .start_i(start), .beat_i(beat), .idx_i(seen),
    .data_i, .station_addr_i, .promisc_i(cfg.promisc),
    .all_mcast_i(cfg.all_mcast), .mcast_hit_i, .pass_o(pass)
  );

  rx_crc_strip #(.CRC_LEN(CRC_LEN)) u_strip (
    .clk_i, .rst_ni, .start_i(start), .beat_i(beat), .strip_i(strip_eff),
    .kill_i(drop_n), .data_i, .wr_o(buf_wr_o), .data_o(buf_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      strip_q    <= 1'b0;
      done_o     <= 1'b0;
      accept_o   <= 1'b0;
      byte_cnt_o <= '0;
      oversize_o <= 1'b0;
    end else begin
      if (start)     in_frame_q <= !eof_i;
      else if (last) in_frame_q <= 1'b0;
      if (in_frame_q | start) drop_q <= drop_n;
      if (start) strip_q <= cfg.strip_crc;
      done_o <= last;
      if (last) begin
        accept_o   <= pass & !drop_n;
        byte_cnt_o <= (pass & !drop_n) ? stored : '0;
      end
      // set has priority over the CPU clear
      if (beat & over)         oversize_o <= 1'b1;
      else if (oversize_clr_i) oversize_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_accept_chk.sv
module rx_accept_chk #(
  parameter int unsigned MAX_LEN = 2048,
  parameter int unsigned CW      = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          sof_i,
  input logic          rx_en_i,
  input logic          oversize_clr_i,
  input logic          in_frame_q,
  input logic          buf_wr_o,
  input logic          done_o,
  input logic          accept_o,
  input logic [CW-1:0] byte_cnt_o,
  input logic          oversize_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_q && !(valid_i && sof_i && rx_en_i)) |=> (!buf_wr_o && !done_o)); // R1

  AST_DROP_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !accept_o) |-> (byte_cnt_o == '0)); // R12

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (byte_cnt_o <= CW'(MAX_LEN))); // R9

  AST_OVS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oversize_o && !oversize_clr_i) |=> oversize_o); // R10

  AST_WR_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> $past(valid_i)); // R13
endmodule

bind rx_accept_ctrl rx_accept_chk #(.MAX_LEN(MAX_LEN), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
  .rx_en_i(rx_en_i), .oversize_clr_i(oversize_clr_i), .in_frame_q(in_frame_q),
  .buf_wr_o(buf_wr_o), .done_o(done_o), .accept_o(accept_o),
  .byte_cnt_o(byte_cnt_o), .oversize_o(oversize_o)
);

// File: tb/tb_rx_accept_ctrl.sv
module tb_rx_accept_ctrl;
  localparam int MAX_LEN = 2048;
  localparam int CW = $clog2(MAX_LEN + 2);
  localparam logic [47:0] STN = 48'h5A_34_12_CD_AB_02;

  logic clk = 0, rst_ni = 0;
  logic valid = 0, sof = 0, eof = 0, col = 0;
  logic [7:0] data = 0;
  logic rx_en = 0, promisc = 0, all_mcast = 0, strip = 0, col_abort = 0, fdx = 0;
  logic mc_hit = 0, ovs_clr = 0;
  logic buf_wr, done, accept, oversize;
  logic [7:0] buf_data;
  logic [CW-1:0] byte_cnt;

  int checks = 0, errors = 0;
  int wr_n = 0;
  logic [7:0] wr_buf [4096];
  logic [7:0] fb [4096];

  always #10 clk = ~clk;

  rx_accept_ctrl #(.MAX_LEN(MAX_LEN), .CRC_LEN(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .col_i(col), .rx_en_i(rx_en), .promisc_i(promisc),
    .all_mcast_i(all_mcast), .strip_crc_i(strip), .col_abort_i(col_abort),
    .full_duplex_i(fdx), .mcast_hit_i(mc_hit), .station_addr_i(STN),
    .oversize_clr_i(ovs_clr), .buf_wr_o(buf_wr), .buf_data_o(buf_data),
    .done_o(done), .accept_o(accept), .byte_cnt_o(byte_cnt), .oversize_o(oversize)
  );

  always @(negedge clk) if (buf_wr) begin
    if (wr_n < 4096) wr_buf[wr_n] = buf_data;
    wr_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // dk: 0 own unicast, 1 foreign unicast, 2 broadcast, 3 multicast
  task automatic run_frame(input int len, input int dk, input int col_at,
                           input int rxoff_at, input bit seen, input string req);
    bit exp_acc, mc, kill;
    int exp_cnt, bad;
    for (int i = 0; i < len; i++) begin
      if (i < 6) begin
        case (dk)
          0: fb[i] = STN[8*i +: 8];
          1: fb[i] = (i == 5) ? STN[8*i +: 8] ^ 8'h01 : STN[8*i +: 8];
          2: fb[i] = 8'hFF;
          default: fb[i] = (i == 0) ? 8'h01 : 8'h5E + 8'(i);
        endcase
      end else fb[i] = 8'((i * 7 + len) & 255);
    end
    mc = (dk >= 2);
    if (len < 6) exp_acc = promisc;
    else exp_acc = promisc | (dk == 2) | (mc ? (all_mcast | mc_hit) : (dk == 0));
    kill = (col_at >= 0) && col_abort && !fdx;
    if (kill || len > MAX_LEN) exp_acc = 0;
    exp_cnt = !exp_acc ? 0 : (strip ? ((len >= 4) ? len - 4 : 0) : len);
    wr_n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      valid = 1; sof = (i == 0); eof = (i == len - 1); data = fb[i];
      col = (i == col_at);
      if (i == rxoff_at) rx_en = 0;
    end
    @(negedge clk);
    valid = 0; sof = 0; eof = 0; col = 0;
    if (seen) begin
      chk(done == 1'b1, {req, " R12 done"}, int'(done), 1);
      chk(accept == exp_acc, {req, " accept"}, int'(accept), int'(exp_acc));
      chk(int'(byte_cnt) == exp_cnt, {req, " count"}, int'(byte_cnt), exp_cnt);
    end else chk(done == 1'b0, {req, " R1 ignored done"}, int'(done), 0);
    @(negedge clk);
    chk(done == 1'b0, {req, " R12 pulse width"}, int'(done), 0);
    if (!seen) chk(wr_n == 0, {req, " R1 ignored writes"}, wr_n, 0);
    else if (exp_acc) begin
      chk(wr_n == exp_cnt, {req, " R13 write count"}, wr_n, exp_cnt);
      bad = 0;
      for (int i = 0; i < exp_cnt && i < wr_n; i++) if (wr_buf[i] !== fb[i]) bad++;
      chk(bad == 0, {req, " R7 write data"}, bad, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!buf_wr && !done && !accept && byte_cnt == 0 && !oversize,
        "R1 reset outputs", int'({buf_wr, done, accept, oversize}), 0);
    run_frame(12, 0, -1, -1, 0, "R1 disabled");
    rx_en = 1;

    // address mode sweep: R2 R3 R4 R5 R6 R7
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 2; a++)
        for (int h = 0; h < 2; h++)
          for (int dk = 0; dk < 4; dk++)
            for (int s = 0; s < 2; s++) begin
              promisc = p[0]; all_mcast = a[0]; mc_hit = h[0]; strip = s[0];
              run_frame(10 + dk * 3 + s, dk, -1, -1, 1, "R2 R3 R4 R6 sweep");
            end

    // short frames: R5 and the R6 lower bound
    all_mcast = 0; mc_hit = 0;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int len = 1; len < 6; len++) begin
          promisc = p[0]; strip = s[0];
          run_frame(len, 0, -1, -1, 1, "R5 short frame");
        end
    promisc = 0;

    // collisions: R11
    strip = 0;
    col_abort = 1; fdx = 0; run_frame(20, 0, 8, -1, 1, "R11 abort");
    chk(wr_n < 20, "R11 writes stopped", wr_n, 9);
    col_abort = 1; fdx = 1; run_frame(20, 0, 8, -1, 1, "R11 full duplex");
    col_abort = 0; fdx = 0; run_frame(20, 0, 8, -1, 1, "R11 disabled");

    // length limit: R9 R10
    strip = 0; run_frame(MAX_LEN, 0, -1, -1, 1, "R9 max len");
    strip = 1; run_frame(MAX_LEN, 0, -1, -1, 1, "R9 max len strip");
    chk(oversize == 1'b0, "R9 no oversize at limit", int'(oversize), 0);
    strip = 0; run_frame(MAX_LEN + 1, 0, -1, -1, 1, "R9 oversize");
    chk(oversize == 1'b1, "R9 oversize set", int'(oversize), 1);
    run_frame(30, 0, -1, -1, 1, "R10 sticky frame");
    chk(oversize == 1'b1, "R10 sticky held", int'(oversize), 1);
    @(negedge clk); ovs_clr = 1;
    @(negedge clk); ovs_clr = 0;
    chk(oversize == 1'b0, "R10 cleared", int'(oversize), 0);
    chk(done == 1'b0 && buf_wr == 1'b0, "R10 clear has no frame effect",
        int'({done, buf_wr}), 0);

    // receiver disable mid-frame: R8
    run_frame(24, 0, -1, 10, 1, "R8 finish current");
    run_frame(24, 0, -1, -1, 0, "R8 later ignored");
    chk(rx_en == 1'b0, "R8 setup", int'(rx_en), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule